// File: doc/BRIEF.md
# Flag-Driven Circular Receive Slot Ring

This block runs a ring of message slots that a receive path fills and software empties. The ring covers a contiguous band of slot indices, from slot 5 up to slot 11 by default. Each slot carries a message made of an identifier and a data word. Each slot also has two flags of its own: an occupied flag and an overflow flag. There is no occupancy counter. Whether a slot may take a new message depends only on its own occupied flag, and only software clears that flag.

Incoming messages arrive on a valid/ready stream. The ring never applies back-pressure, so `in_ready` is always high and a beat is taken on every cycle in which `in_valid` is high. A beat that lands on a slot that is still occupied is not stored. It is dropped, the overflow flag of that slot is set, and `ovf_irq` pulses for one cycle. Software reads the slot at the read pointer through a plain read port. It then releases that slot with a clear strobe, and the read pointer moves on to the next slot. Both pointers are visible on status pins as absolute slot indices.

Top module: `rxq_ring_mgr`

## Requirements
- R1: After reset, `wr_ptr` and `rd_ptr` both equal the first slot index (5). All occupied flags and all overflow flags are 0, and `ovf_irq` is 0.
- R2: A beat taken while the slot at `wr_ptr` is not occupied is stored in that slot. The slot's occupied flag (bit `slot-5` of `full_flags`) is set, and `wr_ptr` advances by one.
- R3: When `wr_ptr` advances from the last slot (11), it moves to the first slot (5).
- R4: `rd_data`, `rd_id` and `rd_full` always show the contents and the occupied flag of the slot at `rd_ptr`.
- R5: A clear strobe on the slot at `rd_ptr`, while that slot is occupied, clears its occupied flag. `rd_ptr` then advances by one, wrapping from 11 to 5. Without such a strobe, `rd_ptr` does not change.
- R6: A clear strobe on an occupied slot other than the one at `rd_ptr` clears only that slot's flag. `rd_ptr` is unchanged.
- R7: Filling every slot raises no interrupt. `ovf_irq` is 0 in every cycle that follows a cycle without an overflow.
- R8: A beat taken while the slot at `wr_ptr` is occupied is discarded. The slot contents and `wr_ptr` do not change. The slot's overflow flag (bit `slot-5` of `ovf_flags`) is set, and `ovf_irq` is high for exactly the next cycle.
- R9: An overflow flag stays set until an overflow-clear strobe names its slot.
- R10: If a write and an occupied-flag clear target the same slot in the same cycle, the clear is applied first. The write is stored without overflow, and the slot stays occupied.
- R11: A clear strobe that names a slot that is not occupied, or an index outside 5..11, changes no flag and no pointer.
- R12: `in_ready` is always 1. The stream is never stalled, and the only loss path is the overflow of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming message beat is valid |
| in_ready | output | 1 | Always 1; the ring takes every beat |
| in_id | input | ID_W (11) | Identifier of the incoming message |
| in_data | input | DATA_W (64) | Data word of the incoming message |
| rd_id | output | ID_W (11) | Identifier stored in the slot at `rd_ptr` |
| rd_data | output | DATA_W (64) | Data word stored in the slot at `rd_ptr` |
| rd_full | output | 1 | Occupied flag of the slot at `rd_ptr` |
| clr_full_valid | input | 1 | Strobe: clear one slot's occupied flag |
| clr_full_idx | input | clog2(LAST+1) (4) | Absolute index of the slot to release |
| clr_ovf_valid | input | 1 | Strobe: clear one slot's overflow flag |
| clr_ovf_idx | input | clog2(LAST+1) (4) | Absolute index of the overflow flag to clear |
| wr_ptr | output | clog2(LAST+1) (4) | Slot the next beat will target |
| rd_ptr | output | clog2(LAST+1) (4) | Slot software should read next |
| full_flags | output | LAST-FIRST+1 (7) | Occupied flags; bit 0 is the first slot |
| ovf_flags | output | LAST-FIRST+1 (7) | Overflow flags; bit 0 is the first slot |
| ovf_irq | output | 1 | One-cycle pulse for each discarded beat |

## Verification
The ring is first driven with a run of writes that fills it from empty across the wrap point. This tells a correct wrap apart from a pointer that overshoots or stops. The run is followed by an in-order release and by a write onto an occupied slot. The overflow case is checked on the flags and the pulse, and also on the read port, which shows that the original message survived. Out-of-order clears, repeated clears and out-of-range clears separate "flag only" behaviour from behaviour that moves the pointer. A write and a clear aimed at the same slot in the same cycle show which of the two takes priority.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_STORE = 2'd1,
    WR_DROP  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
  parameter int FIRST_SLOT = 5,
  parameter int LAST_SLOT  = 11,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] FIRST_IX = IDX_W'(FIRST_SLOT);
  localparam logic [IDX_W-1:0] LAST_IX  = IDX_W'(LAST_SLOT);

  logic [IDX_W-1:0] ptr_next;

  always_comb begin
    ptr_next = ptr;
    if (adv) begin
      if (ptr == LAST_IX) ptr_next = FIRST_IX;
      else                ptr_next = ptr + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= FIRST_IX;
    else        ptr <= ptr_next;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == LAST_IX) |=> (ptr == FIRST_IX)); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr)); // R5
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int NSLOT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] set_full,
  input  logic [NSLOT-1:0] clr_full,
  input  logic [NSLOT-1:0] set_ovf,
  input  logic [NSLOT-1:0] clr_ovf,
  output logic [NSLOT-1:0] full_q,
  output logic [NSLOT-1:0] ovf_q
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q[s] <= 1'b0;
        ovf_q[s]  <= 1'b0;
      end else begin
        // clear is applied before set: a same-cycle store keeps the slot busy
        full_q[s] <= (full_q[s] & ~clr_full[s]) | set_full[s];
        ovf_q[s]  <= (ovf_q[s] & ~clr_ovf[s]) | set_ovf[s];
      end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[s] && !clr_ovf[s]) |=> ovf_q[s]); // R9
    AST_FULL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_full[s] && !set_full[s]) |=> !full_q[s]); // R5
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int NSLOT = 7,
  parameter int W     = 75,
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [OFS_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [OFS_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] slot_q [NSLOT];

  for (genvar s = 0; s < NSLOT; s++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && waddr == OFS_W'(s)) slot_q[s] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (raddr == OFS_W'(s)) rdata = slot_q[s];
    end
  end
endmodule

// File: rtl/rxq_ring_mgr.sv
module rxq_ring_mgr #(
  parameter int FIRST_SLOT = 5,
  parameter int LAST_SLOT  = 11,
  parameter int DATA_W     = 64,
  parameter int ID_W       = 11
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [ID_W-1:0]                    in_id,
  input  logic [DATA_W-1:0]                  in_data,
  output logic [ID_W-1:0]                    rd_id,
  output logic [DATA_W-1:0]                  rd_data,
  output logic                               rd_full,
  input  logic                               clr_full_valid,
  input  logic [$clog2(LAST_SLOT+1)-1:0]     clr_full_idx,
  input  logic                               clr_ovf_valid,
  input  logic [$clog2(LAST_SLOT+1)-1:0]     clr_ovf_idx,
  output logic [$clog2(LAST_SLOT+1)-1:0]     wr_ptr,
  output logic [$clog2(LAST_SLOT+1)-1:0]     rd_ptr,
  output logic [LAST_SLOT-FIRST_SLOT:0]      full_flags,
  output logic [LAST_SLOT-FIRST_SLOT:0]      ovf_flags,
  output logic                               ovf_irq
);
  import rxq_pkg::*;

  localparam int NSLOT = LAST_SLOT - FIRST_SLOT + 1;
  localparam int IDX_W = $clog2(LAST_SLOT + 1);
  localparam int OFS_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int MSG_W = ID_W + DATA_W;
  localparam logic [IDX_W-1:0] FIRST_IX = IDX_W'(FIRST_SLOT);
  localparam logic [IDX_W-1:0] LAST_IX  = IDX_W'(LAST_SLOT);

  if (FIRST_SLOT > LAST_SLOT || LAST_SLOT < 1) begin : g_bad_range
    $error("rxq_ring_mgr: slot range must satisfy 1 <= LAST and FIRST <= LAST");
  end

  logic [OFS_W-1:0] wr_ofs, rd_ofs, clr_ofs, clro_ofs;
  logic             clr_hit, clro_hit, busy_eff, rd_adv;
  wr_kind_e         wr_kind;
  logic [NSLOT-1:0] set_full_v, clr_full_v, set_ovf_v, clr_ovf_v;
  logic [MSG_W-1:0] rd_msg;

  assign in_ready = 1'b1;
  assign wr_ofs   = OFS_W'(wr_ptr - FIRST_IX);
  assign rd_ofs   = OFS_W'(rd_ptr - FIRST_IX);
  assign clr_ofs  = OFS_W'(clr_full_idx - FIRST_IX);
  assign clro_ofs = OFS_W'(clr_ovf_idx - FIRST_IX);

  always_comb begin
    clr_hit  = clr_full_valid && clr_full_idx >= FIRST_IX && clr_full_idx <= LAST_IX;
    clro_hit = clr_ovf_valid && clr_ovf_idx >= FIRST_IX && clr_ovf_idx <= LAST_IX;
    // a same-cycle release of the write slot frees it for this beat
    busy_eff = full_flags[wr_ofs] && !(clr_hit && clr_full_idx == wr_ptr);
    rd_adv   = clr_hit && clr_full_idx == rd_ptr && full_flags[rd_ofs];
    if (!in_valid)     wr_kind = WR_NONE;
    else if (busy_eff) wr_kind = WR_DROP;
    else               wr_kind = WR_STORE;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_dec
    assign set_full_v[s] = (wr_kind == WR_STORE) && wr_ofs == OFS_W'(s);
    assign set_ovf_v[s]  = (wr_kind == WR_DROP) && wr_ofs == OFS_W'(s);
    assign clr_full_v[s] = clr_hit && clr_ofs == OFS_W'(s);
    assign clr_ovf_v[s]  = clro_hit && clro_ofs == OFS_W'(s);
  end

  rxq_ptr #(.FIRST_SLOT(FIRST_SLOT), .LAST_SLOT(LAST_SLOT), .IDX_W(IDX_W)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .adv(wr_kind == WR_STORE), .ptr(wr_ptr));

  rxq_ptr #(.FIRST_SLOT(FIRST_SLOT), .LAST_SLOT(LAST_SLOT), .IDX_W(IDX_W)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .adv(rd_adv), .ptr(rd_ptr));

  rxq_flags #(.NSLOT(NSLOT)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_full(set_full_v), .clr_full(clr_full_v),
    .set_ovf(set_ovf_v), .clr_ovf(clr_ovf_v),
    .full_q(full_flags), .ovf_q(ovf_flags));

  rxq_store #(.NSLOT(NSLOT), .W(MSG_W), .OFS_W(OFS_W)) u_store (
    .clk(clk), .we(wr_kind == WR_STORE), .waddr(wr_ofs),
    .wdata({in_id, in_data}), .raddr(rd_ofs), .rdata(rd_msg));

  assign rd_id   = rd_msg[MSG_W-1:DATA_W];
  assign rd_data = rd_msg[DATA_W-1:0];
  assign rd_full = full_flags[rd_ofs];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_irq <= 1'b0;
    else        ovf_irq <= (wr_kind == WR_DROP);
  end

  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full_flags[wr_ofs] && !(clr_full_valid && clr_full_idx == wr_ptr)) |=> ovf_irq); // R8
  AST_DROP_KEEPS_WPTR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full_flags[wr_ofs] && !(clr_full_valid && clr_full_idx == wr_ptr)) |=> $stable(wr_ptr)); // R8
  AST_QUIET_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !ovf_irq); // R7
  AST_OFFRANGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_full_valid && clr_full_idx > LAST_IX && !in_valid) |=> $stable(full_flags)); // R11
endmodule

// File: tb/rxq_ring_mgr_test.sv
`timescale 1ns/1ps
module rxq_ring_mgr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] in_id = '0;
  logic [63:0] in_data = '0;
  logic [10:0] rd_id;
  logic [63:0] rd_data;
  logic        rd_full;
  logic        clr_full_valid = 1'b0;
  logic [3:0]  clr_full_idx = '0;
  logic        clr_ovf_valid = 1'b0;
  logic [3:0]  clr_ovf_idx = '0;
  logic [3:0]  wr_ptr, rd_ptr;
  logic [6:0]  full_flags, ovf_flags;
  logic        ovf_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rxq_ring_mgr uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_data(in_data), .rd_id(rd_id), .rd_data(rd_data),
    .rd_full(rd_full), .clr_full_valid(clr_full_valid), .clr_full_idx(clr_full_idx),
    .clr_ovf_valid(clr_ovf_valid), .clr_ovf_idx(clr_ovf_idx), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .full_flags(full_flags), .ovf_flags(ovf_flags), .ovf_irq(ovf_irq));

  function automatic logic [63:0] dat(int i);
    return 64'hA5C3_0000_0000_0000 | 64'(i * 17 + 3);
  endfunction
  function automatic logic [10:0] idv(int i);
    return 11'(i * 5 + 100);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {wr, clr_full, clr_ovf, idx[4], exp_wr[4], exp_rd[4], exp_full[7], exp_ovf[7], exp_irq}
  localparam int NV = 15;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,4'd0, 4'd6, 4'd5,7'h01,7'h00,1'b0},  // R2 first store
    {1'b1,1'b0,1'b0,4'd0, 4'd7, 4'd5,7'h03,7'h00,1'b0},
    {1'b1,1'b0,1'b0,4'd0, 4'd8, 4'd5,7'h07,7'h00,1'b0},
    {1'b1,1'b0,1'b0,4'd0, 4'd9, 4'd5,7'h0F,7'h00,1'b0},
    {1'b1,1'b0,1'b0,4'd0, 4'd10,4'd5,7'h1F,7'h00,1'b0},
    {1'b1,1'b0,1'b0,4'd0, 4'd11,4'd5,7'h3F,7'h00,1'b0},
    {1'b0,1'b1,1'b0,4'd5, 4'd11,4'd6,7'h3E,7'h00,1'b0},  // R5 in-order release
    {1'b1,1'b0,1'b0,4'd0, 4'd5, 4'd6,7'h7E,7'h00,1'b0},  // R3 wrap
    {1'b1,1'b0,1'b0,4'd0, 4'd6, 4'd6,7'h7F,7'h00,1'b0},  // R7 full, no irq
    {1'b1,1'b0,1'b0,4'd0, 4'd6, 4'd6,7'h7F,7'h02,1'b1},  // R8 overflow on slot 6
    {1'b0,1'b0,1'b0,4'd0, 4'd6, 4'd6,7'h7F,7'h02,1'b0},  // R8 pulse ends, R9 sticky
    {1'b0,1'b1,1'b0,4'd9, 4'd6, 4'd6,7'h6F,7'h02,1'b0},  // R6 out-of-order clear
    {1'b0,1'b1,1'b0,4'd9, 4'd6, 4'd6,7'h6F,7'h02,1'b0},  // R11 clear of empty slot
    {1'b0,1'b0,1'b1,4'd6, 4'd6, 4'd6,7'h6F,7'h00,1'b0},  // R9 overflow clear
    {1'b1,1'b1,1'b0,4'd6, 4'd7, 4'd7,7'h6F,7'h00,1'b0}   // R10 same-slot clear+write
  };

  task automatic idle_inputs();
    in_valid = 1'b0; clr_full_valid = 1'b0; clr_ovf_valid = 1'b0;
    clr_full_idx = '0; clr_ovf_idx = '0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset();
    chk("R1 wr_ptr", 64'(wr_ptr), 64'd5);
    chk("R1 rd_ptr", 64'(rd_ptr), 64'd5);
    chk("R1 full_flags", 64'(full_flags), 64'd0);
    chk("R1 ovf_flags", 64'(ovf_flags), 64'd0);
    chk("R1 ovf_irq", 64'(ovf_irq), 64'd0);
    chk("R12 in_ready", 64'(in_ready), 64'd1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_reset();

    for (int i = 0; i < NV; i++) begin
      in_valid       = VEC[i][29];
      clr_full_valid = VEC[i][28];
      clr_ovf_valid  = VEC[i][27];
      clr_full_idx   = VEC[i][26:23];
      clr_ovf_idx    = VEC[i][26:23];
      in_data        = dat(i);
      in_id          = idv(i);
      @(negedge clk);
      chk("R2 R3 wr_ptr", 64'(wr_ptr), 64'(VEC[i][22:19]));
      chk("R5 R6 rd_ptr", 64'(rd_ptr), 64'(VEC[i][18:15]));
      chk("R2 R10 full_flags", 64'(full_flags), 64'(VEC[i][14:8]));
      chk("R8 R9 ovf_flags", 64'(ovf_flags), 64'(VEC[i][7:1]));
      chk("R7 R8 ovf_irq", 64'(ovf_irq), 64'(VEC[i][0]));
      if (i == 10) begin
        // slot 6 must still hold the message of vector 1 after the dropped beat
        chk("R8 kept data", rd_data, dat(1));
        chk("R8 kept id", 64'(rd_id), 64'(idv(1)));
      end
    end
    idle_inputs();

    // R4: read port shows slot 7, written by vector 2
    chk("R4 rd_full", 64'(rd_full), 64'd1);
    chk("R4 rd_data", rd_data, dat(2));
    chk("R4 rd_id", 64'(rd_id), 64'(idv(2)));

    // R11: out-of-range clears leave everything alone
    clr_full_valid = 1'b1; clr_full_idx = 4'd3;
    clr_ovf_valid = 1'b1; clr_ovf_idx = 4'd12;
    @(negedge clk);
    clr_full_idx = 4'd12;
    @(negedge clk);
    idle_inputs();
    chk("R11 full_flags", 64'(full_flags), 64'h6F);
    chk("R11 rd_ptr", 64'(rd_ptr), 64'd7);
    chk("R11 wr_ptr", 64'(wr_ptr), 64'd7);

    // R1: reset in the middle of traffic
    do_reset();
    check_reset();

    // R7 and R3: fill all slots, no interrupt, pointer wraps to first slot
    for (int k = 0; k < 7; k++) begin
      in_valid = 1'b1; in_data = dat(40 + k); in_id = idv(40 + k);
      @(negedge clk);
      chk("R7 no irq on fill", 64'(ovf_irq), 64'd0);
    end
    idle_inputs();
    chk("R3 wr_ptr wrapped", 64'(wr_ptr), 64'd5);
    chk("R7 all full", 64'(full_flags), 64'h7F);
    chk("R4 rd_data slot5", rd_data, dat(40));

    // R5: release slot 5, read port moves to slot 6
    clr_full_valid = 1'b1; clr_full_idx = 4'd5;
    @(negedge clk);
    idle_inputs();
    chk("R5 rd_ptr", 64'(rd_ptr), 64'd6);
    chk("R5 rd_data slot6", rd_data, dat(41));
    chk("R5 full_flags", 64'(full_flags), 64'h7E);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule